// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address sequence for a four-beat burst access into a synchronous SRAM array. A start address is captured on a rising clock edge when one of two active-low address strobes is asserted. One strobe comes from the processor and is qualified by an active-low chip enable. The other comes from the cache controller and is not qualified. After the capture, each clock edge that sees the active-low advance input asserted steps a two-bit beat counter. The upper address bits stay unchanged for the whole burst.

A static order input sets how the low two address bits follow from the start value and the beat count. In interleaved order they are the start bits XOR the count. In linear order they are the start bits plus the count, with the sum wrapping inside the four-word block. The sequencer drives the full current address together with registered flags. These flags tell the array whether the last edge captured a new address, which strobe caused the capture, or whether the counter stepped.

Top module: `burst_addr_gen`

## Requirements
- R1: While the synchronous active-high reset is high, addr_out is zero on the next edge and beat_load, beat_adv and load_from_proc are 0.
- R2: With ce_n low and ads_proc_n low at a rising edge, addr_out equals the sampled addr_in after that edge. beat_load is 1 and load_from_proc is 1 for that cycle.
- R3: With ads_ctrl_n low at an edge, and the processor strobe not qualified (ads_proc_n high or ce_n high), addr_out equals the sampled addr_in after the edge. beat_load is 1 and load_from_proc is 0. This holds whatever the value of ce_n.
- R4: When both strobes are low with ce_n low, the processor strobe wins and load_from_proc is 1.
- R5: With ce_n high, a low ads_proc_n has no effect. The sequencer acts only on ads_ctrl_n and adv_n.
- R6: With no capture and adv_n low at an edge, the beat counter steps by one and beat_adv is 1 for that cycle.
- R7: With mode_linear = 0 (interleaved), the low two bits of addr_out equal the start low bits XOR the beat count.
- R8: With mode_linear = 1 (linear), the low two bits of addr_out equal (start low bits + beat count) mod 4.
- R9: After the fourth step the address returns to the start address. The bits above the low two never change except on a capture.
- R10: With no capture and adv_n high, addr_out keeps its value and beat_load and beat_adv are 0.
- R11: A capture takes priority over a step when adv_n is low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_linear | input | 1 | Burst order: 0 interleaved, 1 linear wrap |
| ce_n | input | 1 | Chip enable, active low; qualifies the processor strobe |
| ads_proc_n | input | 1 | Processor address strobe, active low |
| ads_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current burst word address |
| beat_load | output | 1 | Last edge captured a new start address |
| beat_adv | output | 1 | Last edge stepped the beat counter |
| load_from_proc | output | 1 | The capture at the last edge came from the processor strobe |

## Verification
The hold check assumes the order input stays steady while the sequencer is idle, because addr_out follows mode_linear combinationally. The stimulus therefore changes the order only in a cycle that also asserts the controller strobe, so every order change comes together with a fresh capture. The capture checks assume addr_in and the strobes are steady at the sampling edge. The bench drives all inputs half a cycle away from that edge. Random strobes, chip enable and advance are mixed with directed four-beat bursts in both orders from a non-aligned start.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        ACT_HOLD      = 2'd0,
        ACT_STEP      = 2'd1,
        ACT_LOAD_PROC = 2'd2,
        ACT_LOAD_CTRL = 2'd3
    } act_e;

    // Strobe priority: qualified processor strobe, then controller strobe,
    // then advance, else hold.
    function automatic act_e decode_act(
        input logic ce_n,
        input logic ads_proc_n,
        input logic ads_ctrl_n,
        input logic adv_n
    );
        if (!ce_n && !ads_proc_n)
            return ACT_LOAD_PROC;
        else if (!ads_ctrl_n)
            return ACT_LOAD_CTRL;
        else if (!adv_n)
            return ACT_STEP;
        else
            return ACT_HOLD;
    endfunction

    function automatic logic is_load(input act_e a);
        return (a == ACT_LOAD_PROC) || (a == ACT_LOAD_CTRL);
    endfunction

endpackage

// File: rtl/burst_strobe_arb.sv
module burst_strobe_arb
    import burst_pkg::*;
(
    input  logic ce_n,
    input  logic ads_proc_n,
    input  logic ads_ctrl_n,
    input  logic adv_n,
    output act_e act
);

    always_comb begin
        act = decode_act(ce_n, ads_proc_n, ads_ctrl_n, adv_n);
    end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  act_e              act,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_q,
    output logic [BEAT_W-1:0] cnt_q,
    output act_e              last_act_q
);

    localparam logic [BEAT_W-1:0] CNT_ONE = BEAT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q     <= '0;
            cnt_q      <= '0;
            last_act_q <= ACT_HOLD;
        end else begin
            last_act_q <= act;
            unique case (act)
                ACT_LOAD_PROC, ACT_LOAD_CTRL: begin
                    base_q <= addr_in;
                    cnt_q  <= '0;
                end
                ACT_STEP: cnt_q <= cnt_q + CNT_ONE;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [BEAT_W-1:0] cnt,
    input  order_e            order,
    output logic [ADDR_W-1:0] addr
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic [BEAT_W-1:0] lo_ilv;
    logic [BEAT_W-1:0] lo_lin;
    logic [BEAT_W-1:0] lo_sel;

    // Interleaved order: one XOR gate per counter bit.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign lo_ilv[b] = base[b] ^ cnt[b];
    end

    // Linear order: BEAT_W-bit add wraps inside the block.
    assign lo_lin = base[BEAT_W-1:0] + cnt;

    always_comb begin
        lo_sel = (order == ORD_LINEAR) ? lo_lin : lo_ilv;
    end

    if (HI_W > 0) begin : g_hi
        assign addr = {base[ADDR_W-1:BEAT_W], lo_sel};
    end else begin : g_nohi
        assign addr = lo_sel;
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_linear,
    input  logic              ce_n,
    input  logic              ads_proc_n,
    input  logic              ads_ctrl_n,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              beat_load,
    output logic              beat_adv,
    output logic              load_from_proc
);

    act_e              act;
    act_e              last_act;
    logic [ADDR_W-1:0] base;
    logic [BEAT_W-1:0] cnt;
    order_e            order;

    assign order = mode_linear ? ORD_LINEAR : ORD_INTERLEAVE;

    burst_strobe_arb i_arb (
        .ce_n       (ce_n),
        .ads_proc_n (ads_proc_n),
        .ads_ctrl_n (ads_ctrl_n),
        .adv_n      (adv_n),
        .act        (act)
    );

    burst_beat_ctr #(
        .ADDR_W (ADDR_W),
        .BEAT_W (BEAT_W)
    ) i_ctr (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .addr_in    (addr_in),
        .base_q     (base),
        .cnt_q      (cnt),
        .last_act_q (last_act)
    );

    burst_addr_map #(
        .ADDR_W (ADDR_W),
        .BEAT_W (BEAT_W)
    ) i_map (
        .base  (base),
        .cnt   (cnt),
        .order (order),
        .addr  (addr_out)
    );

    assign beat_load      = is_load(last_act);
    assign beat_adv       = (last_act == ACT_STEP);
    assign load_from_proc = (last_act == ACT_LOAD_PROC);

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 16,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_linear,
    input logic              ce_n,
    input logic              ads_proc_n,
    input logic              ads_ctrl_n,
    input logic              adv_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic              beat_load,
    input logic              beat_adv,
    input logic              load_from_proc
);

    logic proc_q;
    logic no_load;
    assign proc_q  = !ce_n && !ads_proc_n;
    assign no_load = !proc_q && ads_ctrl_n;

    a_r2_proc_load: assert property (@(posedge clk) disable iff (rst)
        proc_q |=> (beat_load && load_from_proc && addr_out == $past(addr_in)));

    a_r3_ctrl_load: assert property (@(posedge clk) disable iff (rst)
        (!proc_q && !ads_ctrl_n) |=>
            (beat_load && !load_from_proc && addr_out == $past(addr_in)));

    a_r5_proc_gated: assert property (@(posedge clk) disable iff (rst)
        (ce_n && ads_ctrl_n) |=> !beat_load);

    a_r6_step_flag: assert property (@(posedge clk) disable iff (rst)
        (no_load && !adv_n) |=> (beat_adv && !beat_load));

    a_r9_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        no_load |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (no_load && adv_n) |=>
            ((!$stable(mode_linear) || $stable(addr_out)) && !beat_adv && !beat_load));

    a_r11_flags_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({beat_load, beat_adv}));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
    .ADDR_W (ADDR_W),
    .BEAT_W (BEAT_W)
) i_chk (
    .clk            (clk),
    .rst            (rst),
    .mode_linear    (mode_linear),
    .ce_n           (ce_n),
    .ads_proc_n     (ads_proc_n),
    .ads_ctrl_n     (ads_ctrl_n),
    .adv_n          (adv_n),
    .addr_in        (addr_in),
    .addr_out       (addr_out),
    .beat_load      (beat_load),
    .beat_adv       (beat_adv),
    .load_from_proc (load_from_proc)
);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_linear = 1'b0;
    logic          ce_n = 1'b1;
    logic          ads_proc_n = 1'b1;
    logic          ads_ctrl_n = 1'b1;
    logic          adv_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic          beat_load;
    logic          beat_adv;
    logic          load_from_proc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [AW-1:0] m_start = '0;
    logic [1:0]    m_cnt = '0;
    logic          e_load, e_adv, e_proc;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) i_burst_addr_gen (
        .clk            (clk),
        .rst            (rst),
        .mode_linear    (mode_linear),
        .ce_n           (ce_n),
        .ads_proc_n     (ads_proc_n),
        .ads_ctrl_n     (ads_ctrl_n),
        .adv_n          (adv_n),
        .addr_in        (addr_in),
        .addr_out       (addr_out),
        .beat_load      (beat_load),
        .beat_adv       (beat_adv),
        .load_from_proc (load_from_proc)
    );

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] s,
                                               input logic [1:0] c,
                                               input logic lin);
        logic [1:0] lo;
        lo = lin ? (s[1:0] + c) : (s[1:0] ^ c);
        return {s[AW-1:2], lo};
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] ea,
                         input logic el, input logic ev, input logic ep);
        checks++;
        if (addr_out !== ea || beat_load !== el || beat_adv !== ev || load_from_proc !== ep) begin
            errors++;
            $display("FAIL %s: actual addr=%h load=%b adv=%b proc=%b expected addr=%h load=%b adv=%b proc=%b",
                     tag, addr_out, beat_load, beat_adv, load_from_proc, ea, el, ev, ep);
        end
    endtask

    // Called at a falling edge: apply inputs, update the model, check at next falling edge.
    task automatic step(input logic ap, input logic ac, input logic ce, input logic adv,
                        input logic md, input logic [AW-1:0] a, input string force_tag);
        string tag;
        mode_linear = md; ce_n = ce; ads_proc_n = ap; ads_ctrl_n = ac; adv_n = adv; addr_in = a;
        e_load = 0; e_adv = 0; e_proc = 0;
        if (!ce && !ap) begin
            m_start = a; m_cnt = 0; e_load = 1; e_proc = 1;
            tag = !adv ? "R11" : (!ac ? "R4" : "R2");
        end else if (!ac) begin
            m_start = a; m_cnt = 0; e_load = 1;
            tag = !ap ? "R5" : (!adv ? "R11" : "R3");
        end else if (!adv) begin
            m_cnt = m_cnt + 2'd1; e_adv = 1;
            tag = md ? "R8" : "R7";
        end else begin
            tag = !ap ? "R5" : "R10";
        end
        if (force_tag != "") tag = force_tag;
        @(negedge clk);
        check(tag, exp_addr(m_start, m_cnt, md), e_load, e_adv, e_proc);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic md;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", '0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;

        // R2 + R7: interleaved four-beat burst from low bits 01, then wrap (R9)
        step(0, 1, 0, 1, 0, 16'hABC1, "R2");
        step(1, 1, 0, 0, 0, 16'h0000, "R7");   // 0
        step(1, 1, 0, 0, 0, 16'h0000, "R7");   // 3
        step(1, 1, 0, 0, 0, 16'h0000, "R7");   // 2
        step(1, 1, 0, 0, 0, 16'h0000, "R9");   // back to 1
        step(1, 1, 0, 1, 0, 16'hFFFF, "R10");  // hold
        // R3 + R8: linear burst from 01, controller strobe with ce_n high
        step(1, 0, 1, 1, 1, 16'h1235, "R3");
        step(1, 1, 1, 0, 1, 16'h0000, "R8");   // 2
        step(1, 1, 1, 0, 1, 16'h0000, "R8");   // 3
        step(1, 1, 1, 0, 1, 16'h0000, "R8");   // 0, no carry into upper bits
        step(1, 1, 1, 0, 1, 16'h0000, "R9");   // back to 1
        // R5: processor strobe with ce_n high is ignored
        step(0, 1, 1, 1, 1, 16'h7777, "R5");
        step(0, 1, 1, 0, 1, 16'h7777, "R5");
        // R4: both strobes low
        step(0, 0, 0, 1, 1, 16'h4442, "R4");
        // R11: load beats advance
        step(1, 0, 0, 0, 1, 16'h9993, "R11");
        step(0, 1, 0, 0, 0, 16'h5550, "R11");
        // R6: step raises the advance flag
        step(1, 1, 0, 0, 0, 16'h0000, "R6");

        md = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            logic ap, ac, ce, adv;
            logic [AW-1:0] a;
            ap  = ($urandom % 4) != 0;
            ac  = ($urandom % 5) != 0;
            ce  = $urandom % 2;
            adv = $urandom % 2;
            a   = AW'($urandom);
            if (($urandom % 10) == 0) begin
                md = ~md;
                ac = 1'b0;
            end
            step(ap, ac, ce, adv, md, a, "");
        end

        // R1: reset again mid-burst
        rst = 1'b1;
        @(negedge clk);
        check("R1", '0, 1'b0, 1'b0, 1'b0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule